// File: doc/BRIEF.md
# Egress Source-Port Tag Inserter

This block sits on the egress path that leads to the port of a host processor. It receives frames as a byte stream with valid/ready handshaking. It can push a four-byte VLAN-style tag into each frame, so the host can tell which switch port the frame arrived on. The tag goes in right after the two MAC addresses, which are the first twelve bytes of the frame. It carries TPID 0x8100 and a TCI whose lowest bits hold the ingress port number. Every byte that follows the addresses moves four places later in the frame. A VLAN tag that the frame already carries stays in place and follows the new tag.

A 2-bit egress-type code controls insertion for each frame. Code 11b turns source-port tagging on, and every other code passes the frame through unchanged. The port number and the egress-type code arrive as sideband signals with each byte. They are captured on the first byte of a frame and held for the rest of that frame. While the tag bytes go out, the block holds its input ready low so that no byte from the input is lost. The end-of-frame marker stays on the true last byte of the frame.

Top module: `srcport_tag_inserter`

## Requirements
- R1: After reset, out_valid is low and in_ready is high.
- R2: When the egress-type code captured for a frame is not 11b, the frame leaves byte for byte unchanged, with the same length.
- R3: When the captured code is 11b and the frame is longer than 12 bytes, four bytes are inserted after byte index 11. The first two are 0x81 then 0x00. Every input byte from index 12 onward leaves four positions later.
- R4: The third inserted byte (TCI high: PCP, DEI and VID 11:8) is 0x00. The fourth inserted byte is {6'b0, port}, with the captured 2-bit source port in bits 1:0.
- R5: A VLAN tag already present at input bytes 12 to 15 is kept and leaves at output bytes 16 to 19, directly after the inserted tag.
- R6: out_last is high exactly once per frame, on the frame's final byte, and never on an inserted tag byte.
- R7: For a tagged frame with out_ready held high, in_ready is low for exactly four cycles while in_valid is high.
- R8: The source port and egress type are sampled on the first byte of a frame. Changing them on later bytes of the same frame has no effect.
- R9: While out_valid is high and out_ready is low, out_data and out_last hold their values. No byte is dropped or duplicated under any out_ready pattern.
- R10: A frame of 12 bytes or fewer leaves unchanged even when the code is 11b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can accept an input byte |
| in_data | input | 8 | Input frame byte |
| in_last | input | 1 | Marks the final byte of the input frame |
| in_src_port | input | 2 | Ingress switch port of the frame (sampled on first byte) |
| egress_type | input | 2 | Egress-type code; 11b enables tagging (sampled on first byte) |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream can accept an output byte |
| out_data | output | 8 | Output frame byte |
| out_last | output | 1 | Marks the final byte of the output frame |

## Verification
The assertions assume that the input stream follows ordinary valid/ready rules. Once in_valid is raised, the byte and its sideband stay put until the handshake, and frames are delimited only by in_last. The stimulus changes the input only on the falling clock edge after an accepted byte. It never drops in_valid in the middle of a frame. It varies out_ready only through fixed patterns (always ready, alternating, two in every three cycles), so that the hold and no-loss properties are exercised under real downstream stalls.

// File: rtl/srcport_tag_pkg.sv
package srcport_tag_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [0:0] {
        ST_PASS = 1'b0,
        ST_TAG  = 1'b1
    } ins_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              last;
        logic              is_tag;
    } beat_t;
endpackage

// File: rtl/frame_pos_tracker.sv
module frame_pos_tracker #(
    parameter int HDR_BYTES = 12,
    parameter int PORT_W    = 2,
    parameter int TYPE_W    = 2,
    parameter logic [TYPE_W-1:0] TAG_CODE = '1,
    localparam int POS_W = $clog2(HDR_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              in_last,
    input  logic [PORT_W-1:0] in_src_port,
    input  logic [TYPE_W-1:0] egress_type,
    output logic [PORT_W-1:0] port_q_o,
    output logic              hdr_end
);
    typedef struct packed {
        logic [POS_W-1:0]  pos;
        logic              sof;
        logic [PORT_W-1:0] port;
        logic              en;
    } trk_t;

    trk_t trk_d, trk_q;
    logic en_now;

    always_comb begin
        trk_d  = trk_q;
        en_now = trk_q.sof ? (egress_type == TAG_CODE) : trk_q.en;
        if (accept) begin
            if (trk_q.sof) begin
                trk_d.port = in_src_port;
                trk_d.en   = (egress_type == TAG_CODE);
            end
            if (in_last) begin
                trk_d.pos = '0;
                trk_d.sof = 1'b1;
            end else begin
                trk_d.sof = 1'b0;
                if (trk_q.pos < POS_W'(HDR_BYTES))
                    trk_d.pos = trk_q.pos + 1'b1;
            end
        end
        hdr_end = accept && !in_last && en_now &&
                  (trk_q.pos == POS_W'(HDR_BYTES - 1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q <= '{pos: '0, sof: 1'b1, port: '0, en: 1'b0};
        end else begin
            trk_q <= trk_d;
        end
    end

    assign port_q_o = trk_q.port;

    // R8
    port_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && trk_q.sof) |=> $stable(trk_q.port) && $stable(trk_q.en));

    // R6
    frame_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_last) |=> (trk_q.pos == '0) && trk_q.sof);
endmodule

// File: rtl/tag_byte_gen.sv
module tag_byte_gen #(
    parameter int PORT_W    = 2,
    parameter int TAG_BYTES = 4,
    parameter logic [15:0] TPID = 16'h8100,
    localparam int IDX_W = $clog2(TAG_BYTES),
    localparam int TAG_W = 8 * TAG_BYTES
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [PORT_W-1:0] port,
    output logic [7:0]        tag_byte
);
    logic [15:0]      tci;
    logic [TAG_W-1:0] tag_word;

    always_comb begin
        tci      = {{(16-PORT_W){1'b0}}, port};
        tag_word = TAG_W'({TPID, tci});
        tag_byte = tag_word[8*(TAG_BYTES-1-int'(idx)) +: 8];
    end
endmodule

// File: rtl/egress_out_reg.sv
module egress_out_reg
    import srcport_tag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  beat_t             beat,
    input  logic              out_ready,
    output logic              can_load,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_last
);
    typedef struct packed {
        logic  valid;
        beat_t b;
    } ostg_t;

    ostg_t o_d, o_q;

    always_comb begin
        o_d      = o_q;
        can_load = !o_q.valid || out_ready;
        if (load && can_load) begin
            o_d.valid = 1'b1;
            o_d.b     = beat;
        end else if (out_ready) begin
            o_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign out_valid = o_q.valid;
    assign out_data  = o_q.b.data;
    assign out_last  = o_q.b.last;

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid && $stable(out_data) && $stable(out_last));

    // R6
    tag_not_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && o_q.b.is_tag) |-> !out_last);
endmodule

// File: rtl/srcport_tag_inserter.sv
module srcport_tag_inserter
    import srcport_tag_pkg::*;
#(
    parameter int HDR_BYTES = 12,
    parameter int TAG_BYTES = 4,
    parameter int PORT_W    = 2,
    parameter int TYPE_W    = 2,
    parameter logic [TYPE_W-1:0] TAG_CODE = '1,
    parameter logic [15:0] TPID = 16'h8100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    input  logic [PORT_W-1:0] in_src_port,
    input  logic [TYPE_W-1:0] egress_type,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic              out_last
);
    localparam int IDX_W = $clog2(TAG_BYTES);

    typedef struct packed {
        ins_state_e       st;
        logic [IDX_W-1:0] idx;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              accept;
    logic              hdr_end;
    logic              can_load;
    logic              load;
    logic [PORT_W-1:0] port_q;
    logic [7:0]        tag_byte;
    beat_t             beat;

    frame_pos_tracker #(
        .HDR_BYTES (HDR_BYTES),
        .PORT_W    (PORT_W),
        .TYPE_W    (TYPE_W),
        .TAG_CODE  (TAG_CODE)
    ) u_trk (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .in_last     (in_last),
        .in_src_port (in_src_port),
        .egress_type (egress_type),
        .port_q_o    (port_q),
        .hdr_end     (hdr_end)
    );

    tag_byte_gen #(
        .PORT_W    (PORT_W),
        .TAG_BYTES (TAG_BYTES),
        .TPID      (TPID)
    ) u_tag (
        .idx      (ctl_q.idx),
        .port     (port_q),
        .tag_byte (tag_byte)
    );

    egress_out_reg u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .beat      (beat),
        .out_ready (out_ready),
        .can_load  (can_load),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last)
    );

    always_comb begin
        ctl_d    = ctl_q;
        in_ready = can_load && (ctl_q.st == ST_PASS);
        accept   = in_valid && in_ready;
        load     = accept || ((ctl_q.st == ST_TAG) && can_load);
        if (ctl_q.st == ST_TAG) begin
            beat = '{data: tag_byte, last: 1'b0, is_tag: 1'b1};
        end else begin
            beat = '{data: in_data, last: in_last, is_tag: 1'b0};
        end
        case (ctl_q.st)
            ST_PASS: begin
                if (hdr_end) begin
                    ctl_d.st  = ST_TAG;
                    ctl_d.idx = '0;
                end
            end
            ST_TAG: begin
                if (can_load) begin
                    if (ctl_q.idx == IDX_W'(TAG_BYTES - 1)) begin
                        ctl_d.st  = ST_PASS;
                        ctl_d.idx = '0;
                    end else begin
                        ctl_d.idx = ctl_q.idx + 1'b1;
                    end
                end
            end
            default: ctl_d = '{st: ST_PASS, idx: '0};
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_PASS, idx: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // R7
    stall_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_end |=> !in_ready);

    // R9
    ready_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (out_ready || !out_valid));

    // R3
    tag_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_TAG && can_load && ctl_q.idx == IDX_W'(TAG_BYTES - 1)) |=> in_ready || !out_ready);
endmodule

// File: tb/srcport_tag_inserter_test.sv
module srcport_tag_inserter_test;
    localparam int CLK_PERIOD = 10;
    // {len[7:0], port[1:0], etype[1:0], vlan, rmode[1:0]}
    localparam logic [14:0] VEC [8] = '{
        {8'd20, 2'd1, 2'd3, 1'b0, 2'd0},
        {8'd20, 2'd2, 2'd0, 1'b0, 2'd0},
        {8'd30, 2'd0, 2'd3, 1'b1, 2'd1},
        {8'd16, 2'd2, 2'd3, 1'b0, 2'd2},
        {8'd25, 2'd1, 2'd1, 1'b0, 2'd1},
        {8'd13, 2'd0, 2'd3, 1'b0, 2'd0},
        {8'd40, 2'd2, 2'd2, 1'b1, 2'd2},
        {8'd18, 2'd1, 2'd3, 1'b1, 2'd0}
    };

    logic clk = 0;
    logic rst_n = 0;
    logic in_valid = 0, in_ready, in_last = 0, out_valid, out_ready = 1, out_last;
    logic [7:0] in_data = 0, out_data;
    logic [1:0] in_src_port = 0, egress_type = 0;

    int checks = 0, fails = 0, cyc = 0, stalls = 0;
    int rmode = 0;
    logic [7:0] got[$];
    logic       gotl[$];
    logic [7:0] exp[$];

    srcport_tag_inserter uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .in_src_port(in_src_port),
        .egress_type(egress_type), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        cyc++;
        case (rmode)
            1: out_ready = cyc[0];
            2: out_ready = (cyc % 3) != 0;
            default: out_ready = 1'b1;
        endcase
        #2;
        if (rst_n && out_valid && out_ready) begin
            got.push_back(out_data);
            gotl.push_back(out_last);
        end
        if (rst_n && in_valid && !in_ready) stalls++;
        if (cyc > 100000) begin
            fails++; checks++;
            $display("FAIL watchdog: actual cycles %0d expected < 100000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    function automatic logic [7:0] byte_of(int f, int i, bit vlan);
        if (vlan && i == 12) return 8'h81;
        if (vlan && i == 13) return 8'h00;
        return 8'((f * 37 + i * 13 + 5) & 255);
    endfunction

    task automatic check(string req, bit ok, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic send(int f, int len, bit vlan, logic [1:0] p0, logic [1:0] e0,
                        logic [1:0] p1, logic [1:0] e1);
        got.delete(); gotl.delete(); stalls = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1; in_data = byte_of(f, i, vlan); in_last = (i == len - 1);
            in_src_port = (i == 0) ? p0 : p1;
            egress_type = (i == 0) ? e0 : e1;
            #1;
            while (!in_ready) begin @(negedge clk); #1; end
        end
        @(negedge clk);
        in_valid = 0; in_last = 0;
        repeat (40) @(negedge clk);
    endtask

    task automatic build_exp(int f, int len, bit vlan, logic [1:0] p, logic [1:0] e);
        exp.delete();
        for (int i = 0; i < len; i++) begin
            exp.push_back(byte_of(f, i, vlan));
            if (i == 11 && e == 2'b11 && len > 12) begin
                exp.push_back(8'h81); exp.push_back(8'h00);
                exp.push_back(8'h00); exp.push_back({6'b0, p});
            end
        end
    endtask

    task automatic compare(string req);
        int bad = -1, nlast = 0;
        check({req, " length"}, got.size() == exp.size(), got.size(), exp.size());
        for (int i = 0; i < got.size() && i < exp.size(); i++)
            if (bad < 0 && got[i] !== exp[i]) bad = i;
        if (bad >= 0) check({req, " data"}, 0, got[bad], exp[bad]);
        else check({req, " data"}, 1, 0, 0);
        for (int i = 0; i < gotl.size(); i++) if (gotl[i]) nlast++;
        check("R6 last count", nlast == 1 && gotl.size() > 0 && gotl[gotl.size()-1],
              nlast, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #2;
        // R1
        check("R1 out_valid after reset", out_valid == 0, out_valid, 0);
        rst_n = 1;
        @(negedge clk); #2;
        check("R1 in_ready after reset", in_ready == 1, in_ready, 1);

        for (int v = 0; v < 8; v++) begin
            int len; logic [1:0] p, e; bit vl;
            len = int'(VEC[v][14:7]); p = VEC[v][6:5]; e = VEC[v][4:3];
            vl = VEC[v][2]; rmode = int'(VEC[v][1:0]);
            build_exp(v, len, vl, p, e);
            send(v, len, vl, p, e, p, e);
            if (e == 2'b11) compare(vl ? "R5 R3 R4 R9 tagged" : "R3 R4 R9 tagged");
            else compare("R2 R9 passthrough");
            if (e == 2'b11 && rmode == 0)
                check("R7 stall cycles", stalls == 4, stalls, 4);
        end

        rmode = 0;
        // R10: 12-byte and 5-byte frames with tagging code
        build_exp(20, 12, 0, 2'd1, 2'd3);
        send(20, 12, 0, 2'd1, 2'd3, 2'd1, 2'd3);
        compare("R10 12-byte frame");
        check("R10 no stall", stalls == 0, stalls, 0);
        build_exp(21, 5, 0, 2'd2, 2'd3);
        send(21, 5, 0, 2'd2, 2'd3, 2'd2, 2'd3);
        compare("R10 5-byte frame");

        // R8: sideband changed after the first byte
        build_exp(22, 20, 0, 2'd1, 2'd3);
        send(22, 20, 0, 2'd1, 2'd3, 2'd2, 2'd0);
        compare("R8 sideband held (tagged)");
        build_exp(23, 20, 0, 2'd2, 2'd0);
        send(23, 20, 0, 2'd2, 2'd0, 2'd1, 2'd3);
        compare("R8 sideband held (untagged)");

        // R4: port 2 under stalled output
        rmode = 1;
        build_exp(24, 14, 0, 2'd2, 2'd3);
        send(24, 14, 0, 2'd2, 2'd3, 2'd2, 2'd3);
        compare("R4 port 2 tag");
        check("R4 TCI low byte", got.size() > 15 && got[15] == 8'h02,
              got.size() > 15 ? got[15] : -1, 2);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule